// File: doc/BRIEF.md
# Memory-Mapped GPIO Data Port

This block is a 32-pin general-purpose I/O port that sits on a simple APB-style register bus. It keeps the output value, the output-enable (direction) mask, and the pull enable and pull polarity masks for the pads. It also returns the sampled state of the input pins. Every register holds one bit per pin. All bus accesses are aligned 32-bit words.

Next to the plain output register there are two write-only alias addresses. One sets output bits and the other clears them. Software can therefore change a single pin without a read-modify-write sequence, and does not race against other writers. Input pins pass through a two-flop synchroniser before they are read back. A per-pin bypass mask selects the raw pin value instead, for signals already timed to the bus clock.

The bus has no wait states. A write takes effect on the clock edge that ends the access phase. A read returns its data combinationally during the access.

Top module: `gpio_port`

## Requirements
- R1: After the active-low asynchronous reset, every register is zero. The pad output, the output-enable, the pull-enable and the pull-select vectors are all zero.
- R2: A write to offset 0x00 replaces the whole output register. A read of 0x00 returns the stored value, and pad_out_o shows it.
- R3: A write to offset 0x10 sets each output bit whose write-data bit is 1. All other output bits keep their value.
- R4: A write to offset 0x14 clears each output bit whose write-data bit is 1. All other output bits keep their value.
- R5: Offset 0x08 is the direction register and reads back as written. A bit value of 1 drives the matching pad_oe_o bit high, making that pin an output. A bit value of 0 makes it an input.
- R6: A read of offset 0x04 returns each non-bypassed pin through two synchroniser flops. A pin change is not visible after one rising clock edge and is visible after two.
- R7: Offset 0x0C is a read/write bypass mask. For each bit set to 1, a read of 0x04 returns the raw pin value with no delay.
- R8: Offsets 0x18 (pull enable) and 0x1C (pull select, 1 means pull-up) are read/write registers. They drive pull_en_o and pull_up_o directly.
- R9: Offsets 0x10 and 0x14 read as zero. Unmapped or misaligned addresses read as zero, and writes to them change nothing.
- R10: A register changes only on an access-phase write, where psel_i, penable_i and pwrite_i are all high. A setup-phase cycle or a read leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | Peripheral select |
| penable_i | input | 1 | Access-phase strobe |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 8 | Byte address |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, valid during access |
| pad_in_i | input | 32 | Pin input levels (asynchronous) |
| pad_out_o | output | 32 | Output value to pads |
| pad_oe_o | output | 32 | Output enable per pin |
| pull_en_o | output | 32 | Pull resistor enable per pin |
| pull_up_o | output | 32 | Pull polarity per pin, 1 = up |

## Verification
The hardest behaviour to observe from the ports is the synchroniser latency. The readback value must lag a pin change by exactly two edges, and the bus itself takes more than one edge per transfer. To reach this, the stimulus changes pad_in_i at a falling edge and starts a read in that same half-cycle. The read then samples after a single rising edge and must still return the old value. A second read that follows straight after must return the new value. The same pin change is repeated with the bypass mask set, and the first read must then show the new value at once.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned NUM_REGS = 8;
  localparam int unsigned IDX_W    = $clog2(NUM_REGS);

  // word index = byte offset / 4
  typedef enum logic [IDX_W-1:0] {
    IDX_OUT   = 3'd0,
    IDX_IN    = 3'd1,
    IDX_DIR   = 3'd2,
    IDX_BYP   = 3'd3,
    IDX_SET   = 3'd4,
    IDX_CLR   = 3'd5,
    IDX_PEN   = 3'd6,
    IDX_PUP   = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  reg_idx_e         idx_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] out_o,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] byp_o,
  output logic [WIDTH-1:0] pen_o,
  output logic [WIDTH-1:0] pup_o
);
  logic [WIDTH-1:0] out_q, dir_q, byp_q, pen_q, pup_q;
  logic [WIDTH-1:0] out_d;

  always_comb begin
    out_d = out_q;
    if (wr_en_i) begin
      unique case (idx_i)
        IDX_OUT: out_d = wdata_i;
        IDX_SET: out_d = out_q | wdata_i;
        IDX_CLR: out_d = out_q & ~wdata_i;
        default: out_d = out_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      dir_q <= '0;
      byp_q <= '0;
      pen_q <= '0;
      pup_q <= '0;
    end else begin
      out_q <= out_d;
      if (wr_en_i && idx_i == IDX_DIR) dir_q <= wdata_i;
      if (wr_en_i && idx_i == IDX_BYP) byp_q <= wdata_i;
      if (wr_en_i && idx_i == IDX_PEN) pen_q <= wdata_i;
      if (wr_en_i && idx_i == IDX_PUP) pup_q <= wdata_i;
    end
  end

  assign out_o = out_q;
  assign dir_o = dir_q;
  assign byp_o = byp_q;
  assign pen_o = pen_q;
  assign pup_o = pup_q;

  a_r3_set_keeps_others: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx_i == IDX_SET) |=> (out_o == ($past(out_o) | $past(wdata_i))));

  a_r4_clr_keeps_others: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx_i == IDX_CLR) |=> (out_o == ($past(out_o) & ~$past(wdata_i))));

  a_r2_out_replaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx_i == IDX_OUT) |=> (out_o == $past(wdata_i)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [WIDTH-1:0]  pwdata_i,
  output logic [WIDTH-1:0]  prdata_o,
  input  logic [WIDTH-1:0]  pad_in_i,
  output logic [WIDTH-1:0]  pad_out_o,
  output logic [WIDTH-1:0]  pad_oe_o,
  output logic [WIDTH-1:0]  pull_en_o,
  output logic [WIDTH-1:0]  pull_up_o
);
  localparam int unsigned MAP_TOP = IDX_W + 2;

  logic             hit;
  reg_idx_e         idx;
  logic             wr_en;
  logic [WIDTH-1:0] out_r, dir_r, byp_r, pen_r, pup_r, sync_in, pin_rd;

  // aligned and inside the eight-word window
  assign hit   = (paddr_i[1:0] == 2'b00) && (paddr_i[ADDR_W-1:MAP_TOP] == '0);
  assign idx   = reg_idx_e'(paddr_i[MAP_TOP-1:2]);
  assign wr_en = psel_i && penable_i && pwrite_i && hit;

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .idx_i   (idx),
    .wdata_i (pwdata_i),
    .out_o   (out_r),
    .dir_o   (dir_r),
    .byp_o   (byp_r),
    .pen_o   (pen_r),
    .pup_o   (pup_r)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (sync_in)
  );

  assign pin_rd = (byp_r & pad_in_i) | (~byp_r & sync_in);

  always_comb begin
    prdata_o = '0;
    if (psel_i && !pwrite_i && hit) begin
      unique case (idx)
        IDX_OUT: prdata_o = out_r;
        IDX_IN:  prdata_o = pin_rd;
        IDX_DIR: prdata_o = dir_r;
        IDX_BYP: prdata_o = byp_r;
        IDX_PEN: prdata_o = pen_r;
        IDX_PUP: prdata_o = pup_r;
        default: prdata_o = '0;
      endcase
    end
  end

  assign pad_out_o = out_r;
  assign pad_oe_o  = dir_r;
  assign pull_en_o = pen_r;
  assign pull_up_o = pup_r;

  a_r5_dir_to_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && idx == IDX_DIR) |=> (pad_oe_o == $past(pwdata_i)));

  a_r9_alias_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && !pwrite_i && (!hit || idx == IDX_SET || idx == IDX_CLR)) |-> (prdata_o == '0));

  a_r10_no_write_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(psel_i && penable_i && pwrite_i) |=> ($stable(pad_out_o) && $stable(pad_oe_o)
                                           && $stable(pull_en_o) && $stable(pull_up_o)));
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  localparam time CLK_P = 10ns;
  localparam int  NVEC  = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0, prdata, pad_in = '0;
  logic [31:0] pad_out, pad_oe, pull_en, pull_up;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .pull_en_o(pull_en), .pull_up_o(pull_up)
  );

  // {addr, wdata, expected pad_out}
  localparam logic [71:0] VEC [NVEC] = '{
    {8'h00, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
    {8'h10, 32'h0000_F0F0, 32'hA5A5_FFFF},
    {8'h14, 32'hA500_000F, 32'h00A5_FFF0},
    {8'h00, 32'h0000_0000, 32'h0000_0000},
    {8'h10, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {8'h14, 32'h8000_0001, 32'h7FFF_FFFE},
    {8'h10, 32'h0000_0000, 32'h7FFF_FFFE},
    {8'h14, 32'h0000_0000, 32'h7FFF_FFFE}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%08h exp=%08h", req, act, exp);
    end
  endtask

  // tasks are entered and left at a falling edge
  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk) penable = 1;
    @(negedge clk) begin psel = 0; penable = 0; pwrite = 0; end
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk) penable = 1;
    #(CLK_P/4) d = prdata;
    @(negedge clk) begin psel = 0; penable = 0; end
  endtask

  initial begin
    logic [31:0] rd;
    #(CLK_P*3);
    @(negedge clk);
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pull_en", pull_en, 32'h0);
    check("R1 pull_up", pull_up, 32'h0);
    rst_n = 1;
    @(negedge clk);
    bus_rd(8'h08, rd); check("R1 dir read", rd, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      bus_wr(VEC[i][71:64], VEC[i][63:32]);
      check(VEC[i][71:64] == 8'h00 ? "R2 out write" :
            VEC[i][71:64] == 8'h10 ? "R3 set" : "R4 clear", pad_out, VEC[i][31:0]);
    end
    bus_rd(8'h00, rd); check("R2 out readback", rd, 32'h7FFF_FFFE);

    bus_wr(8'h08, 32'h00FF_00F0);
    check("R5 oe", pad_oe, 32'h00FF_00F0);
    bus_rd(8'h08, rd); check("R5 dir readback", rd, 32'h00FF_00F0);

    bus_wr(8'h18, 32'h1234_5678); bus_wr(8'h1C, 32'h8765_4321);
    check("R8 pull_en", pull_en, 32'h1234_5678);
    check("R8 pull_up", pull_up, 32'h8765_4321);
    bus_rd(8'h1C, rd); check("R8 pull_up readback", rd, 32'h8765_4321);

    bus_rd(8'h10, rd); check("R9 set reads zero", rd, 32'h0);
    bus_rd(8'h14, rd); check("R9 clr reads zero", rd, 32'h0);
    bus_wr(8'h20, 32'hFFFF_FFFF); bus_wr(8'h02, 32'h0);
    check("R9 unmapped write out", pad_out, 32'h7FFF_FFFE);
    check("R9 unmapped write oe", pad_oe, 32'h00FF_00F0);
    bus_rd(8'h20, rd); check("R9 unmapped read", rd, 32'h0);
    bus_rd(8'h01, rd); check("R9 misaligned read", rd, 32'h0);

    // R10: setup phase only, then idle cycles
    psel = 1; pwrite = 1; paddr = 8'h00; pwdata = 32'hDEAD_BEEF; penable = 0;
    @(negedge clk) begin psel = 0; pwrite = 0; end
    @(negedge clk);
    check("R10 setup-only write", pad_out, 32'h7FFF_FFFE);

    pad_in = 32'hCAFE_F00D;
    bus_rd(8'h04, rd); check("R6 one edge old", rd, 32'h0);
    bus_rd(8'h04, rd); check("R6 two edges new", rd, 32'hCAFE_F00D);

    bus_wr(8'h0C, 32'hFFFF_0000);
    bus_rd(8'h0C, rd); check("R7 bypass readback", rd, 32'hFFFF_0000);
    pad_in = 32'h1357_2468;
    bus_rd(8'h04, rd); check("R7 mixed bypass", rd, 32'h1357_F00D);
    bus_rd(8'h04, rd); check("R6 settled", rd, 32'h1357_2468);

    rst_n = 0; #1;
    check("R1 async reset out", pad_out, 32'h0);
    check("R1 async reset pull", pull_up, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P*5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule